// File: doc/BRIEF.md
# Source-Synchronous Sample Deframer

This block sits behind the input capture registers of a radio transceiver's receive data port. It turns the lane traffic back into parallel 12-bit I/Q words. The block runs in one of two port modes.

In double-data-rate mode, every data-clock cycle delivers two halves of a 6-bit lane, one captured on the rising edge and one on the falling edge, together with the frame bit seen on each edge. Two edges carry one sample. In single-data-rate mode, every clock edge delivers a whole 12-bit sample with one frame bit.

In both modes a frame holds four sample slots: I then Q of the first channel, then I then Q of the second. The frame line is high for the first two slots and low for the last two. In double-data-rate mode that gives eight edges with the pattern high, high, high, high, low, low, low, low. The block finds alignment from the frame line's low-to-high change and checks every later frame against the pattern. For each good frame it presents all four words at once with a one-cycle valid strobe.

Top module: `ddr_deframe_rx`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the cycle after it is released, sample_valid_o, locked_o and misalign_o are 0.
- R2: The port mode (1 = double-data-rate, 0 = single-data-rate) is taken from mode_lvds_i only while reset is asserted. Changing mode_lvds_i at any other time has no effect on the decoded words.
- R3: While unlocked, alignment is taken only from a slot whose frame bits are both 1 and whose preceding frame bit was 0. In double-data-rate mode this means the rise must land on the rising-edge half. A rise seen only on the falling-edge half does not lock, and neither does a frame line that stays high.
- R4: locked_o goes to 1 in the cycle after the slot that carried the frame rise is captured. That slot is taken as slot 0.
- R5: In double-data-rate mode, the rising-edge half of a slot forms sample bits 11:6 and the falling-edge half forms bits 5:0.
- R6: In single-data-rate mode, each clock delivers one whole 12-bit sample, and the frame pattern over the four slots is 1,1,0,0.
- R7: Slots 0..3 of a frame map to ch0_i_o, ch0_q_o, ch1_i_o, ch1_q_o. sample_valid_o pulses for one cycle after slot 3 of a good frame is captured, and only while locked.
- R8: A locked frame that breaks the pattern in any slot gives no valid pulse. locked_o falls and misalign_o rises after its slot 3. misalign_o then stays 1 until reset.
- R9: After a loss of lock, the block searches again and relocks on the next valid frame rise. misalign_o stays set through the relock.
- R10: In double-data-rate mode, a slot whose rising-edge and falling-edge frame bits differ breaks the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock (capture-register domain) |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_lvds_i | input | 1 | Port mode, 1 = two edges per sample, 0 = one edge per sample |
| lane_rise_i | input | 6 | Lane half captured on the rising edge |
| frm_rise_i | input | 1 | Frame bit captured on the rising edge |
| lane_fall_i | input | 6 | Lane half captured on the falling edge |
| frm_fall_i | input | 1 | Frame bit captured on the falling edge |
| bus_sdr_i | input | 12 | Whole sample in single-data-rate mode |
| frm_sdr_i | input | 1 | Frame bit in single-data-rate mode |
| sample_valid_o | output | 1 | One-cycle strobe for a completed good frame |
| ch0_i_o | output | 12 | Channel 0 in-phase word |
| ch0_q_o | output | 12 | Channel 0 quadrature word |
| ch1_i_o | output | 12 | Channel 1 in-phase word |
| ch1_q_o | output | 12 | Channel 1 quadrature word |
| locked_o | output | 1 | Frame alignment held |
| misalign_o | output | 1 | Sticky flag: a locked frame broke the pattern |

## Verification
The bench drives a frame rise that lands only on the falling-edge half. A design that locks on any transition would align half a sample off and emit words with their halves swapped. A frame with one corrupted slot and a frame whose two edge halves disagree both have to drop lock with no strobe. A design that checks only the rise, or only one half, would instead emit wrong words as good data. The bench also flips the mode input in mid-stream, which exposes a design that reads the mode live: it would switch to whole-bus decoding. It then checks that relock keeps the sticky flag, and that single-data-rate framing uses its own 1,1,0,0 pattern.

// File: rtl/ddr_deframe_pkg.sv
package ddr_deframe_pkg;

    localparam int SAMPLE_W_DEF = 12;
    localparam int NUM_CH       = 2;
    localparam int SLOTS        = 2 * NUM_CH;   // I and Q per channel
    localparam int SLOT_W       = $clog2(SLOTS);

    typedef enum logic {
        PORT_SDR = 1'b0,
        PORT_DDR = 1'b1
    } port_mode_e;

    typedef enum logic {
        TRK_SEARCH = 1'b0,
        TRK_LOCKED = 1'b1
    } trk_state_e;

    // Frame bits seen for one sample slot: first and second capture edge.
    typedef struct packed {
        logic lead;
        logic trail;
    } frm_pair_t;

    // Expected frame level of a slot: high for the first half of the frame.
    function automatic logic slot_frame_level(input int idx, input int slots);
        return (idx < (slots / 2));
    endfunction

endpackage

// File: rtl/ddr_lane_mux.sv
module ddr_lane_mux
    import ddr_deframe_pkg::*;
#(
    parameter int LANE_W = 6,
    localparam int WORD_W = 2 * LANE_W
) (
    input  port_mode_e         mode,
    input  logic [LANE_W-1:0]  lane_rise,
    input  logic               frm_rise,
    input  logic [LANE_W-1:0]  lane_fall,
    input  logic               frm_fall,
    input  logic [WORD_W-1:0]  bus_sdr,
    input  logic               frm_sdr,
    output logic [WORD_W-1:0]  word,
    output frm_pair_t          frm
);

    always_comb begin
        if (mode == PORT_DDR) begin
            // upper half travels on the first (rising) edge
            word      = {lane_rise, lane_fall};
            frm.lead  = frm_rise;
            frm.trail = frm_fall;
        end else begin
            word      = bus_sdr;
            frm.lead  = frm_sdr;
            frm.trail = frm_sdr;
        end
    end

endmodule

// File: rtl/ddr_frame_tracker.sv
module ddr_frame_tracker
    import ddr_deframe_pkg::*;
#(
    parameter int N_SLOTS = 4,
    localparam int IDX_W = $clog2(N_SLOTS)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  frm_pair_t        frm,
    output logic             cap_en,
    output logic [IDX_W-1:0] cap_idx,
    output logic             commit,
    output logic             locked_o,
    output logic             misalign_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLOTS - 1);

    trk_state_e       state_q, state_d;
    logic [IDX_W-1:0] slot_q, slot_d;
    logic             err_q, err_d;
    logic             prev_trail_q;
    logic             miss_q, miss_d;

    logic rise_ok;
    logic exp_lvl;
    logic slot_bad;

    assign rise_ok  = !prev_trail_q && frm.lead && frm.trail;
    assign exp_lvl  = slot_frame_level(int'(slot_q), N_SLOTS);
    assign slot_bad = (frm.lead != exp_lvl) || (frm.trail != exp_lvl);

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        err_d   = err_q;
        miss_d  = miss_q;
        cap_en  = 1'b0;
        cap_idx = slot_q;
        commit  = 1'b0;
        unique case (state_q)
            TRK_SEARCH: begin
                if (rise_ok) begin
                    cap_en  = 1'b1;
                    cap_idx = '0;
                    slot_d  = IDX_W'(1);
                    err_d   = 1'b0;
                    state_d = TRK_LOCKED;
                end
            end
            TRK_LOCKED: begin
                cap_en = 1'b1;
                if (slot_q == LAST_IDX) begin
                    slot_d = '0;
                    err_d  = 1'b0;
                    if (err_q || slot_bad) begin
                        state_d = TRK_SEARCH;
                        miss_d  = 1'b1;
                    end else begin
                        commit = 1'b1;
                    end
                end else begin
                    slot_d = slot_q + IDX_W'(1);
                    err_d  = err_q | slot_bad;
                end
            end
            default: state_d = TRK_SEARCH;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q      <= TRK_SEARCH;
            slot_q       <= '0;
            err_q        <= 1'b0;
            miss_q       <= 1'b0;
            prev_trail_q <= 1'b1;   // a line already high is not a rise
        end else begin
            state_q      <= state_d;
            slot_q       <= slot_d;
            err_q        <= err_d;
            miss_q       <= miss_d;
            prev_trail_q <= frm.trail;
        end
    end

    assign locked_o   = (state_q == TRK_LOCKED);
    assign misalign_o = miss_q;

endmodule

// File: rtl/ddr_sample_assembler.sv
module ddr_sample_assembler #(
    parameter int SAMPLE_W = 12,
    parameter int N_SLOTS  = 4,
    localparam int IDX_W = $clog2(N_SLOTS)
) (
    input  logic                               clk_i,
    input  logic                               rst_i,
    input  logic                               cap_en,
    input  logic [IDX_W-1:0]                   cap_idx,
    input  logic [SAMPLE_W-1:0]                word,
    input  logic                               commit,
    output logic                               valid_o,
    output logic [N_SLOTS-1:0][SAMPLE_W-1:0]   words_o
);

    logic [N_SLOTS-2:0][SAMPLE_W-1:0] bank_q;
    logic [N_SLOTS-1:0][SAMPLE_W-1:0] out_q;
    logic                             valid_q;

    // hold slots 0..N-2; the last slot goes straight to the output
    for (genvar k = 0; k < N_SLOTS - 1; k++) begin : g_bank
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                bank_q[k] <= '0;
            end else if (cap_en && (cap_idx == IDX_W'(k))) begin
                bank_q[k] <= word;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            valid_q <= commit;
            if (commit) begin
                out_q <= {word, bank_q};
            end
        end
    end

    assign valid_o = valid_q;
    assign words_o = out_q;

endmodule

// File: rtl/ddr_deframe_rx.sv
module ddr_deframe_rx
    import ddr_deframe_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    localparam int LANE_W = SAMPLE_W / 2
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                mode_lvds_i,
    input  logic [LANE_W-1:0]   lane_rise_i,
    input  logic                frm_rise_i,
    input  logic [LANE_W-1:0]   lane_fall_i,
    input  logic                frm_fall_i,
    input  logic [SAMPLE_W-1:0] bus_sdr_i,
    input  logic                frm_sdr_i,
    output logic                sample_valid_o,
    output logic [SAMPLE_W-1:0] ch0_i_o,
    output logic [SAMPLE_W-1:0] ch0_q_o,
    output logic [SAMPLE_W-1:0] ch1_i_o,
    output logic [SAMPLE_W-1:0] ch1_q_o,
    output logic                locked_o,
    output logic                misalign_o
);

    port_mode_e                     mode_q;
    logic [SAMPLE_W-1:0]            word;
    frm_pair_t                      frm;
    logic                           cap_en;
    logic [SLOT_W-1:0]              cap_idx;
    logic                           commit;
    logic [SLOTS-1:0][SAMPLE_W-1:0] words;

    // mode is latched only during reset
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= port_mode_e'(mode_lvds_i);
        end
    end

    ddr_lane_mux #(.LANE_W(LANE_W)) mux_i (
        .mode      (mode_q),
        .lane_rise (lane_rise_i),
        .frm_rise  (frm_rise_i),
        .lane_fall (lane_fall_i),
        .frm_fall  (frm_fall_i),
        .bus_sdr   (bus_sdr_i),
        .frm_sdr   (frm_sdr_i),
        .word      (word),
        .frm       (frm)
    );

    ddr_frame_tracker #(.N_SLOTS(SLOTS)) trk_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .frm        (frm),
        .cap_en     (cap_en),
        .cap_idx    (cap_idx),
        .commit     (commit),
        .locked_o   (locked_o),
        .misalign_o (misalign_o)
    );

    ddr_sample_assembler #(.SAMPLE_W(SAMPLE_W), .N_SLOTS(SLOTS)) asm_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .word    (word),
        .commit  (commit),
        .valid_o (sample_valid_o),
        .words_o (words)
    );

    assign ch0_i_o = words[0];
    assign ch0_q_o = words[1];
    assign ch1_i_o = words[2];
    assign ch1_q_o = words[3];

endmodule

// File: rtl/ddr_deframe_chk.sv
module ddr_deframe_chk (
    input logic clk_i,
    input logic rst_i,
    input logic sample_valid_o,
    input logic locked_o,
    input logic misalign_o
);

    logic rst_d = 1'b0;

    always_ff @(posedge clk_i) rst_d <= rst_i;

    always @(negedge clk_i) begin
        if (rst_d) begin
            assert_reset_clear_R1: assert (!sample_valid_o && !locked_o && !misalign_o)
                else $error("R1: outputs not cleared by reset");
        end
    end

    assert_valid_needs_lock_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_valid_o |-> locked_o);

    assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_valid_o |=> !sample_valid_o);

    assert_frame_end_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(locked_o) |-> ##3 (sample_valid_o || !locked_o));

    assert_misalign_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        misalign_o |=> misalign_o);

    assert_break_drops_lock_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(misalign_o) |-> (!locked_o && !sample_valid_o));

endmodule

bind ddr_deframe_rx ddr_deframe_chk chk_i (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .sample_valid_o (sample_valid_o),
    .locked_o       (locked_o),
    .misalign_o     (misalign_o)
);

// File: tb/ddr_deframe_rx_tb_top.sv
module ddr_deframe_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_i = 1'b1;
    logic [5:0]  lane_rise = '0;
    logic        frm_rise = 1'b0;
    logic [5:0]  lane_fall = '0;
    logic        frm_fall = 1'b0;
    logic [11:0] bus_sdr = '0;
    logic        frm_sdr = 1'b0;

    logic        valid;
    logic [11:0] i0, q0, i1, q1;
    logic        locked, misalign;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    ddr_deframe_rx dut_i (
        .clk_i(clk), .rst_i(rst), .mode_lvds_i(mode_i),
        .lane_rise_i(lane_rise), .frm_rise_i(frm_rise),
        .lane_fall_i(lane_fall), .frm_fall_i(frm_fall),
        .bus_sdr_i(bus_sdr), .frm_sdr_i(frm_sdr),
        .sample_valid_o(valid),
        .ch0_i_o(i0), .ch0_q_o(q0), .ch1_i_o(i1), .ch1_q_o(q1),
        .locked_o(locked), .misalign_o(misalign)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit   m_armed = 0;
    bit   m_ddr = 1;
    bit   m_lock = 0, m_mis = 0, m_valid = 0, m_err = 0, m_prev = 1;
    int   m_slot = 0;
    logic [11:0] m_q[$];
    logic [11:0] m_out[4];

    always @(posedge clk) begin
        logic [11:0] w;
        logic a, b, lvl, bad;
        if (rst) begin
            m_armed = 1; m_ddr = mode_i;
            m_lock = 0; m_mis = 0; m_valid = 0; m_err = 0; m_prev = 1; m_slot = 0;
            m_q.delete();
        end else begin
            if (m_ddr) begin w = {lane_rise, lane_fall}; a = frm_rise; b = frm_fall; end
            else       begin w = bus_sdr; a = frm_sdr; b = frm_sdr; end
            m_valid = 0;
            if (!m_lock) begin
                if (!m_prev && a && b) begin
                    m_lock = 1; m_slot = 1; m_err = 0;
                    m_q.delete(); m_q.push_back(w);
                end
            end else begin
                lvl = (m_slot < 2);
                bad = (a != lvl) || (b != lvl);
                m_q.push_back(w);
                if (m_slot == 3) begin
                    if (m_err || bad) begin m_lock = 0; m_mis = 1; end
                    else begin
                        m_valid = 1;
                        for (int k = 0; k < 4; k++) m_out[k] = m_q[k];
                    end
                    m_slot = 0; m_err = 0; m_q.delete();
                end else begin
                    m_slot++; m_err = m_err | bad;
                end
            end
            m_prev = b;
        end
        #1;
        if (m_armed && !done) begin
            chk("R4 model locked", locked, m_lock);
            chk("R8 model misalign", misalign, m_mis);
            chk("R7 model valid", valid, m_valid);
            if (m_valid) begin
                chk("R5/R6 model ch0_i", i0, m_out[0]);
                chk("R5/R6 model ch0_q", q0, m_out[1]);
                chk("R5/R6 model ch1_i", i1, m_out[2]);
                chk("R5/R6 model ch1_q", q1, m_out[3]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic slot_ddr(input logic [11:0] w, input logic fr, input logic ff);
        lane_rise = w[11:6]; lane_fall = w[5:0];
        frm_rise = fr; frm_fall = ff;
        bus_sdr = ~w; frm_sdr = ~fr;
        @(negedge clk);
    endtask

    task automatic slot_sdr(input logic [11:0] w, input logic f);
        bus_sdr = w; frm_sdr = f;
        lane_rise = ~w[5:0]; lane_fall = ~w[11:6];
        frm_rise = ~f; frm_fall = f;
        @(negedge clk);
    endtask

    // bad_slot < 0: clean frame; split: halves disagree in the bad slot
    task automatic frame_ddr(input logic [11:0] a0, input logic [11:0] a1,
                             input logic [11:0] a2, input logic [11:0] a3,
                             input int bad_slot, input bit split);
        logic [11:0] ws[4];
        ws[0] = a0; ws[1] = a1; ws[2] = a2; ws[3] = a3;
        for (int k = 0; k < 4; k++) begin
            logic lvl;
            lvl = (k < 2);
            if (k == bad_slot) begin
                if (split) slot_ddr(ws[k], lvl, !lvl);
                else       slot_ddr(ws[k], !lvl, !lvl);
            end else begin
                slot_ddr(ws[k], lvl, lvl);
            end
        end
    endtask

    task automatic frame_sdr(input logic [11:0] a0, input logic [11:0] a1,
                             input logic [11:0] a2, input logic [11:0] a3,
                             input int bad_slot);
        logic [11:0] ws[4];
        ws[0] = a0; ws[1] = a1; ws[2] = a2; ws[3] = a3;
        for (int k = 0; k < 4; k++) begin
            logic lvl;
            lvl = (k < 2);
            slot_sdr(ws[k], (k == bad_slot) ? !lvl : lvl);
        end
    endtask

    task automatic check_words(input string tag, input logic [11:0] a0, input logic [11:0] a1,
                               input logic [11:0] a2, input logic [11:0] a3);
        chk({tag, " valid"}, valid, 1);
        chk({tag, " ch0_i"}, i0, a0);
        chk({tag, " ch0_q"}, q0, a1);
        chk({tag, " ch1_i"}, i1, a2);
        chk({tag, " ch1_q"}, q1, a3);
    endtask

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 valid after reset", valid, 0);
        chk("R1 locked after reset", locked, 0);
        chk("R1 misalign after reset", misalign, 0);

        slot_ddr(12'h000, 0, 0);
        slot_ddr(12'h000, 0, 0);

        // first frame: lock on slot 0
        slot_ddr(12'hA5C, 1, 1);
        chk("R4 locked after rise slot", locked, 1);
        chk("R7 no valid mid-frame", valid, 0);
        slot_ddr(12'h3F1, 1, 1);
        slot_ddr(12'h90E, 0, 0);
        slot_ddr(12'h16B, 0, 0);
        check_words("R5 R7 first frame", 12'hA5C, 12'h3F1, 12'h90E, 12'h16B);

        frame_ddr(12'hFC0, 12'h03F, 12'h555, 12'hAAA, -1, 0);
        check_words("R5 back-to-back frame", 12'hFC0, 12'h03F, 12'h555, 12'hAAA);

        // mode toggled outside reset: decoding must stay double-data-rate
        mode_i = 1'b0;
        slot_ddr(12'h123, 1, 1);
        chk("R7 single pulse", valid, 0);
        slot_ddr(12'h456, 1, 1);
        slot_ddr(12'h789, 0, 0);
        slot_ddr(12'hABC, 0, 0);
        check_words("R2 mode ignored", 12'h123, 12'h456, 12'h789, 12'hABC);

        // corrupted slot 2
        frame_ddr(12'h111, 12'h222, 12'h333, 12'h444, 2, 0);
        chk("R8 no valid on break", valid, 0);
        chk("R8 lock dropped", locked, 0);
        chk("R8 misalign set", misalign, 1);

        slot_ddr(12'h000, 0, 0);
        slot_ddr(12'h000, 0, 0);
        chk("R8 misalign sticky", misalign, 1);
        frame_ddr(12'h0F0, 12'h70E, 12'hE07, 12'h5A5, -1, 0);
        check_words("R9 relock", 12'h0F0, 12'h70E, 12'hE07, 12'h5A5);
        chk("R9 misalign kept", misalign, 1);

        // halves disagree in slot 1
        frame_ddr(12'h321, 12'h654, 12'h987, 12'hCBA, 1, 1);
        chk("R10 split halves valid", valid, 0);
        chk("R10 split halves lock", locked, 0);

        // rise only on falling half, then line stays high
        slot_ddr(12'h000, 0, 0);
        slot_ddr(12'hBAD, 0, 1);
        chk("R3 mid-cycle rise", locked, 0);
        slot_ddr(12'hBAD, 1, 1);
        chk("R3 held-high line", locked, 0);
        slot_ddr(12'hBAD, 1, 1);
        slot_ddr(12'h000, 0, 0);
        slot_ddr(12'h000, 0, 0);
        chk("R3 still unlocked", locked, 0);
        frame_ddr(12'h246, 12'h8AC, 12'hE13, 12'h579, -1, 0);
        check_words("R3 relock after clean rise", 12'h246, 12'h8AC, 12'hE13, 12'h579);

        // single-data-rate mode
        rst = 1'b1;
        mode_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 misalign cleared", misalign, 0);
        chk("R1 lock cleared", locked, 0);
        slot_sdr(12'h000, 0);
        slot_sdr(12'h000, 0);
        mode_i = 1'b1;
        frame_sdr(12'hDEA, 12'hBEE, 12'hF00, 12'h0CA, -1);
        check_words("R6 sdr frame", 12'hDEA, 12'hBEE, 12'hF00, 12'h0CA);
        frame_sdr(12'h010, 12'h020, 12'h030, 12'h040, -1);
        check_words("R6 sdr back-to-back", 12'h010, 12'h020, 12'h030, 12'h040);
        frame_sdr(12'h111, 12'h222, 12'h333, 12'h444, 3);
        chk("R8 sdr break misalign", misalign, 1);
        chk("R8 sdr break valid", valid, 0);
        slot_sdr(12'h000, 0);
        summary();
    end

endmodule